// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a station keeps or drops an incoming Ethernet frame, based only on the frame's 48-bit destination address. The receive path presents the address one bit per cycle after frame synchronisation. The filter collects the bits and compares the finished address with three things: the station's own physical address, the all-ones broadcast address and a hashed table of multicast group addresses. One cycle after the last address bit, it registers an accept or reject verdict. The verdict then holds until the next frame begins.

Group addresses are placed in the table and removed from it through a small command port. Each command gets a done pulse and an error flag. The table is indexed by a 6-bit XOR fold of the address, and each slot holds one full address, so a hit is an exact comparison and never a probabilistic one. Slot 0 is kept empty, which leaves 63 usable slots. Two mode inputs widen acceptance: one accepts every address, and the other accepts every multicast address. The station address starts from a parameter value and can be replaced at run time.

Top module: `dest_addr_filter`

## Requirements
- R1: After `frame_start`, each cycle with `bit_valid` high supplies the next address bit on `bit_in`. The first bit becomes address bit 0, which is the multicast flag (1 = group). `dec_valid` stays low until the clock edge that takes the 48th bit. At that edge `dec_valid` rises and `dec_accept` carries the verdict.
- R2: Once `dec_valid` is high, `dec_valid` and `dec_accept` stay constant, and further address bits are ignored. Asserting `frame_start` clears both at the next edge and restarts collection from bit 0.
- R3: An all-ones destination address is always accepted.
- R4: An address with bit 0 equal to 0 is accepted only if it equals the station address, unless promiscuous mode is on. After reset the station address is the parameter `PHYS_DEFAULT`.
- R5: A cycle with `phys_load` high replaces the station address with `phys_value`. Later verdicts compare against the new value only.
- R6: A multicast address that is not broadcast is accepted, with neither mode on, only when the table slot at its hash index is occupied by exactly that address.
- R7: The hash index bit j is the XOR of every address bit i for which i mod 6 equals j.
- R8: A load command (`grp_cmd_delete` = 0) gets `grp_rsp_done` one cycle later. `grp_rsp_err` is set in three cases: the address hashes to index 0, its bit 0 is 0, or its slot already holds a different address. On error the table is unchanged. Reloading an address that is already present succeeds.
- R9: A delete command (`grp_cmd_delete` = 1) empties the slot and succeeds when that slot holds the given address. Otherwise it reports an error and changes nothing.
- R10: With `promisc_en` high when the 48th bit arrives, every address is accepted.
- R11: With `all_mcast_en` high, every address with bit 0 = 1 is accepted. The verdict for addresses with bit 0 = 0 is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Begins a new frame; clears the verdict |
| bit_valid | input | 1 | `bit_in` holds an address bit |
| bit_in | input | 1 | Serial destination address bit |
| promisc_en | input | 1 | Accept every address |
| all_mcast_en | input | 1 | Accept every multicast address |
| phys_load | input | 1 | Replace the station address |
| phys_value | input | 48 | New station address |
| grp_cmd_valid | input | 1 | Group table command strobe |
| grp_cmd_delete | input | 1 | 1 = delete, 0 = load |
| grp_cmd_addr | input | 48 | Group address of the command |
| grp_rsp_done | output | 1 | Command completed (one-cycle pulse) |
| grp_rsp_err | output | 1 | Command failed, table untouched |
| dec_valid | output | 1 | Verdict available |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
A wrong bit counter in the collector would make the verdict appear a cycle early or late, or let trailing bits disturb it. The next frame exposes this as a misplaced `dec_valid` rise or a changing `dec_accept`. A corrupted table slot or valid flag shows up within the first frame that hashes to that slot: the verdict is wrong, or a later load or delete of the same address returns the wrong error flag one cycle after the command. A stale station address is revealed by the first unicast frame after `phys_load`.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
    localparam int DEF_ADDR_W = 48;
    localparam int DEF_HASH_W = 6;

    typedef enum logic {
        GRP_LOAD   = 1'b0,
        GRP_DELETE = 1'b1
    } grp_op_e;
endpackage

// File: rtl/dafilt_collect.sv
module dafilt_collect #(
    parameter int ADDR_W = dafilt_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic [ADDR_W-1:0] addr_full,
    output logic              last_bit
);
    localparam int CNT_W = $clog2(ADDR_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
    } col_st_t;

    col_st_t st_d, st_q;
    logic [ADDR_W-1:0] addr_nx;

    always_comb begin
        st_d     = st_q;
        addr_nx  = st_q.addr;
        last_bit = 1'b0;
        if (frame_start) begin
            st_d.cnt  = '0;
            st_d.addr = '0;
        end else if (bit_valid && (st_q.cnt < CNT_W'(ADDR_W))) begin
            addr_nx[st_q.cnt] = bit_in;
            st_d.addr         = addr_nx;
            st_d.cnt          = st_q.cnt + 1'b1;
            last_bit          = (st_q.cnt == CNT_W'(ADDR_W - 1));
        end
    end

    assign addr_full = addr_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the bit counter never runs past the address width
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(ADDR_W));

    // R2: a frame start always returns collection to bit 0
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st_q.cnt == '0));
endmodule

// File: rtl/dafilt_grp_table.sv
module dafilt_grp_table #(
    parameter int ADDR_W = dafilt_pkg::DEF_ADDR_W,
    parameter int HASH_W = dafilt_pkg::DEF_HASH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic                lk_hit,
    input  logic                cmd_valid,
    input  dafilt_pkg::grp_op_e cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    output logic                rsp_done,
    output logic                rsp_err
);
    import dafilt_pkg::*;

    localparam int DEPTH = 1 << HASH_W;

    function automatic logic [HASH_W-1:0] fold(input logic [ADDR_W-1:0] a);
        logic [HASH_W-1:0] h;
        h = '0;
        for (int i = 0; i < ADDR_W; i++) h[i % HASH_W] ^= a[i];
        return h;
    endfunction

    typedef struct packed {
        logic [DEPTH-1:0] vld;
        logic             done;
        logic             err;
    } tbl_st_t;

    tbl_st_t st_d, st_q;
    logic [ADDR_W-1:0] slot_q [DEPTH];

    logic [HASH_W-1:0] lk_idx, c_idx;
    logic              wr_en;
    logic              c_occ, c_same;

    always_comb begin
        lk_idx = fold(lk_addr);
        lk_hit = (lk_idx != '0) && st_q.vld[lk_idx] && (slot_q[lk_idx] == lk_addr);

        c_idx  = fold(cmd_addr);
        c_occ  = st_q.vld[c_idx];
        c_same = (slot_q[c_idx] == cmd_addr);

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        wr_en     = 1'b0;
        if (cmd_valid) begin
            st_d.done = 1'b1;
            if ((c_idx == '0) || !cmd_addr[0]) begin
                st_d.err = 1'b1;
            end else if (cmd_op == GRP_LOAD) begin
                if (c_occ && !c_same) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.vld[c_idx] = 1'b1;
                    wr_en           = 1'b1;
                end
            end else begin
                if (c_occ && c_same) st_d.vld[c_idx] = 1'b0;
                else                 st_d.err        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) slot_q[c_idx] <= cmd_addr;
    end

    assign rsp_done = st_q.done;
    assign rsp_err  = st_q.err;

    // R8: every response answers a command of the previous cycle
    p_rsp_after_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(cmd_valid));

    // R8: addresses folding to slot 0 are refused
    p_slot0_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (fold(cmd_addr) == '0)) |=> (rsp_done && rsp_err));

    // R6: slot 0 never reports a hit
    p_no_hit_slot0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fold(lk_addr) == '0) |-> !lk_hit);

    // R9: an erroring command leaves the occupancy map untouched
    p_err_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (st_q.vld == $past(st_q.vld)));
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
    parameter int                              ADDR_W       = dafilt_pkg::DEF_ADDR_W,
    parameter int                              HASH_W       = dafilt_pkg::DEF_HASH_W,
    parameter logic [dafilt_pkg::DEF_ADDR_W-1:0] PHYS_DEFAULT = 48'h00A5_1C3E_7700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              promisc_en,
    input  logic              all_mcast_en,
    input  logic              phys_load,
    input  logic [ADDR_W-1:0] phys_value,
    input  logic              grp_cmd_valid,
    input  logic              grp_cmd_delete,
    input  logic [ADDR_W-1:0] grp_cmd_addr,
    output logic              grp_rsp_done,
    output logic              grp_rsp_err,
    output logic              dec_valid,
    output logic              dec_accept
);
    import dafilt_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] phys;
        logic              valid;
        logic              accept;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [ADDR_W-1:0] addr_full;
    logic              last_bit;
    logic              grp_hit;
    logic              is_bcast;
    grp_op_e           cmd_op;

    assign cmd_op = grp_cmd_delete ? GRP_DELETE : GRP_LOAD;

    dafilt_collect #(.ADDR_W(ADDR_W)) collect_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .addr_full   (addr_full),
        .last_bit    (last_bit)
    );

    dafilt_grp_table #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_addr   (addr_full),
        .lk_hit    (grp_hit),
        .cmd_valid (grp_cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (grp_cmd_addr),
        .rsp_done  (grp_rsp_done),
        .rsp_err   (grp_rsp_err)
    );

    always_comb begin
        st_d     = st_q;
        is_bcast = &addr_full;
        if (phys_load) st_d.phys = phys_value;
        if (frame_start) begin
            st_d.valid  = 1'b0;
            st_d.accept = 1'b0;
        end else if (last_bit) begin
            st_d.valid  = 1'b1;
            st_d.accept = promisc_en || is_bcast ||
                          (addr_full[0] ? (all_mcast_en || grp_hit)
                                        : (addr_full == st_q.phys));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phys   <= PHYS_DEFAULT[ADDR_W-1:0];
            st_q.valid  <= 1'b0;
            st_q.accept <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid  = st_q.valid;
    assign dec_accept = st_q.accept;

    // R1: the verdict appears only at the edge taking the last bit
    p_verdict_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(last_bit));

    // R2: a verdict holds until the next frame start
    p_verdict_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !frame_start) |=> (dec_valid && $stable(dec_accept)));

    // R2: frame start clears the verdict
    p_verdict_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!dec_valid && !dec_accept));

    // R3: broadcast is always kept
    p_bcast_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && (&addr_full)) |=> dec_accept);

    // R10: promiscuous mode keeps everything
    p_promisc_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && promisc_en) |=> dec_accept);
endmodule

// File: tb/dest_addr_filter_tb_top.sv
`timescale 1ns/1ps
module dest_addr_filter_tb_top;
    localparam logic [47:0] PHYS0  = 48'h0042_9D10_5E00;
    localparam logic [47:0] PHYS1  = 48'h00C0_FFEE_1234;
    localparam logic [47:0] GRP_A  = 48'h0000_0000_0003; // hash 3
    localparam logic [47:0] GRP_B  = 48'h0000_0000_1043; // hash 3, differs from A
    localparam logic [47:0] GRP_Z  = 48'h0000_0000_0041; // hash 0
    localparam logic [47:0] NOTGRP = 48'h0000_0000_0002; // bit 0 clear
    localparam logic [47:0] GRP_HI = 48'h2000_0000_0001; // bits 0,45 -> hash 9
    localparam logic [47:0] GRP_LO = 48'h0000_0000_0009; // bits 0,3  -> hash 9

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
    logic promisc_en = 1'b0, all_mcast_en = 1'b0, phys_load = 1'b0;
    logic [47:0] phys_value = '0;
    logic grp_cmd_valid = 1'b0, grp_cmd_delete = 1'b0;
    logic [47:0] grp_cmd_addr = '0;
    logic grp_rsp_done, grp_rsp_err, dec_valid, dec_accept;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dest_addr_filter #(.PHYS_DEFAULT(PHYS0)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .bit_valid(bit_valid), .bit_in(bit_in), .promisc_en(promisc_en),
        .all_mcast_en(all_mcast_en), .phys_load(phys_load), .phys_value(phys_value),
        .grp_cmd_valid(grp_cmd_valid), .grp_cmd_delete(grp_cmd_delete),
        .grp_cmd_addr(grp_cmd_addr), .grp_rsp_done(grp_rsp_done),
        .grp_rsp_err(grp_rsp_err), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int j = 0; j < 6; j++)
            for (int k = j; k < 48; k += 6) h[j] = h[j] ^ a[k];
        return h;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_addr(input logic [47:0] a, input int extra, input bit early_chk);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        for (int i = 0; i < 48 + extra; i++) begin
            bit_valid = 1'b1;
            bit_in    = (i < 48) ? a[i] : ~a[i % 48];
            if (early_chk && i == 47) chk("R1 no verdict before last bit", dec_valid, 0);
            @(negedge clk);
            if (i == 47 && extra > 0) chk("R1 verdict after last bit", dec_valid, 1);
        end
        bit_valid = 1'b0;
    endtask

    task automatic expect_verdict(input string req, input bit acc);
        chk(req, {dec_valid, dec_accept}, {1'b1, acc});
    endtask

    task automatic grp_cmd(input bit del, input logic [47:0] a, input bit exp_err, input string req);
        @(negedge clk);
        grp_cmd_valid = 1'b1; grp_cmd_delete = del; grp_cmd_addr = a;
        @(negedge clk);
        grp_cmd_valid = 1'b0;
        chk(req, {grp_rsp_done, grp_rsp_err}, {1'b1, exp_err});
        @(negedge clk);
        chk("R8 done is a single pulse", grp_rsp_done, 0);
    endtask

    task automatic t_reset;
        chk("R1 reset verdict low", {dec_valid, dec_accept}, 0);
        chk("R8 reset no response", grp_rsp_done, 0);
    endtask

    task automatic t_physical;
        send_addr(PHYS0, 0, 1'b1);
        expect_verdict("R4 default station address kept", 1);
        send_addr(PHYS0 ^ 48'h0100_0000_0000, 0, 1'b0);
        expect_verdict("R4 other physical dropped", 0);
    endtask

    task automatic t_broadcast;
        send_addr('1, 0, 1'b0);
        expect_verdict("R3 broadcast kept", 1);
    endtask

    task automatic t_hold_and_clear;
        send_addr(PHYS0, 6, 1'b0);
        expect_verdict("R2 trailing bits ignored", 1);
        repeat (3) @(negedge clk);
        expect_verdict("R2 verdict held", 1);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        chk("R2 frame start clears verdict", {dec_valid, dec_accept}, 0);
    endtask

    task automatic t_phys_reload;
        @(negedge clk) begin phys_load = 1'b1; phys_value = PHYS1; end
        @(negedge clk) phys_load = 1'b0;
        send_addr(PHYS0, 0, 1'b0);
        expect_verdict("R5 old station address dropped", 0);
        send_addr(PHYS1, 0, 1'b0);
        expect_verdict("R5 new station address kept", 1);
    endtask

    task automatic t_groups;
        chk("R7 reference hash A", ref_hash(GRP_A), 3);
        chk("R7 reference hash B", ref_hash(GRP_B), 3);
        send_addr(GRP_A, 0, 1'b0);
        expect_verdict("R6 unloaded group dropped", 0);
        grp_cmd(1'b0, GRP_A, 1'b0, "R8 load A succeeds");
        send_addr(GRP_A, 0, 1'b0);
        expect_verdict("R6 loaded group kept", 1);
        send_addr(GRP_B, 0, 1'b0);
        expect_verdict("R6 same slot other address dropped", 0);
        grp_cmd(1'b0, GRP_B, 1'b1, "R8 conflicting load refused");
        send_addr(GRP_A, 0, 1'b0);
        expect_verdict("R8 table unchanged after refusal", 1);
        grp_cmd(1'b0, GRP_A, 1'b0, "R8 reload same address succeeds");
        grp_cmd(1'b0, GRP_Z, 1'b1, "R8 slot 0 refused");
        grp_cmd(1'b0, NOTGRP, 1'b1, "R8 physical-type address refused");
        grp_cmd(1'b0, GRP_HI, 1'b0, "R7 load high-bit group");
        grp_cmd(1'b0, GRP_LO, 1'b1, "R7 high bit folds into slot 9");
        send_addr(GRP_HI, 0, 1'b0);
        expect_verdict("R7 high-bit group kept", 1);
        grp_cmd(1'b1, GRP_B, 1'b1, "R9 delete absent address refused");
        send_addr(GRP_A, 0, 1'b0);
        expect_verdict("R9 refused delete leaves entry", 1);
        grp_cmd(1'b1, GRP_A, 1'b0, "R9 delete present address");
        send_addr(GRP_A, 0, 1'b0);
        expect_verdict("R9 deleted group dropped", 0);
        grp_cmd(1'b0, GRP_B, 1'b0, "R9 freed slot reusable");
    endtask

    task automatic t_modes;
        all_mcast_en = 1'b1;
        send_addr(GRP_A, 0, 1'b0);
        expect_verdict("R11 any multicast kept", 1);
        send_addr(PHYS0, 0, 1'b0);
        expect_verdict("R11 physical mismatch still dropped", 0);
        all_mcast_en = 1'b0;
        promisc_en = 1'b1;
        send_addr(48'h0012_3456_7890, 0, 1'b0);
        expect_verdict("R10 foreign physical kept", 1);
        send_addr(GRP_LO, 0, 1'b0);
        expect_verdict("R10 foreign multicast kept", 1);
        promisc_en = 1'b0;
        send_addr(48'h0012_3456_7890, 0, 1'b0);
        expect_verdict("R4 filter back after promiscuous", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_physical();
        t_broadcast();
        t_hold_and_clear();
        t_phys_reload();
        t_groups();
        t_modes();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule